// File: doc/BRIEF.md
# Status Input Interrupt Register Bank

This block is a byte-wide register bank that a host reads and writes over a simple address, write-strobe and data port. It watches four external status inputs and turns them into one level-sensitive interrupt request. Each input has its own interrupt enable. Each input also has a sticky flag that is set while the input and its enable are both high, and it stays set until software clears the enable. A separate global enable gates the interrupt output and leaves the per-input enables and the flags untouched. This lets a driver silence every interrupt in one write and restore them in another.

The command register also holds a channel-enable bit, which is driven out as a level to downstream DMA channels. When software takes that bit from 1 to 0, the block emits a single-cycle flush pulse. Downstream logic uses this pulse to reset its channels, empty its FIFOs and clear its underflow and overflow flags. The channels stay idle for as long as the level is low. Reads are combinational on the address.

Top module: `stat_irq_regs`

## Requirements
- R1: After reset every register reads 0x00, and `irq_o`, `chan_en_o` and `chan_flush_o` are all 0.
- R2: The command register sits at offset 0x00. Bits 7:4 are the interrupt enables for status inputs 3:0. Bit 3 is the channel enable. Bits 2:0 always read 0, and writes to them are ignored.
- R3: Status register (offset 0x03) bits 3:0 show the status inputs after a two-flop synchronizer. A change on `stat_i` appears in the readback after the second rising clock edge.
- R4: Status register bit 4+n is the flag for input n. It is set on the first rising edge at which the synchronized input n is 1 and enable n is 1. It stays set after the input returns to 0. It is never set while enable n is 0.
- R5: A flag clears on the edge after its enable is written to 0. If the enable is written back to 1 while the synchronized input is still 1, the flag sets again on the following edge.
- R6: `irq_o` is 1 exactly when the global enable is 1 and at least one flag is set. It follows either change with no extra register stage.
- R7: The control register sits at offset 0x04. Bit 4 is the global interrupt enable, where 1 means enabled. All other bits read 0. Changing the global enable leaves the command register and the flags unchanged.
- R8: `chan_en_o` equals command bit 3 from the edge on which that bit is written.
- R9: `chan_flush_o` is high for exactly one cycle, starting at the edge where command bit 3 is written from 1 to 0. Writes that leave bit 3 at 0, and writes that take it from 0 to 1, give no pulse.
- R10: Writes to the status offset 0x03, and writes to unmapped offsets, change no register. Reads from unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_we | input | 1 | Write strobe: writes `reg_wdata` to `reg_addr` at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| stat_i | input | 4 | Asynchronous status inputs |
| irq_o | output | 1 | Interrupt request |
| chan_en_o | output | 1 | Channel enable level |
| chan_flush_o | output | 1 | One-cycle channel/FIFO/error-flag reset pulse |

## Verification
Register writes take effect at the strobe edge. Readback, `chan_en_o`, `chan_flush_o` and a change in the global gate on `irq_o` are therefore checked in the same cycle, just after that edge. A status input is expected in the readback two edges after it is driven, and its flag one edge after that. A flag cleared by its enable is expected one edge after the write. Each check is queued by the driver just after an edge and compared by the monitor on the following falling edge. The bench also compares the value one edge early at each point where the latency matters, so that an extra or a missing stage is caught.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned STAT_W   = 4;
  localparam int unsigned SYNC_N   = 2;
  // field positions inside the byte
  localparam int unsigned IE_LSB   = DATA_W - STAT_W;
  localparam int unsigned CHEN_BIT = 3;
  localparam int unsigned GIE_BIT  = 4;
  // offsets
  localparam logic [ADDR_W-1:0] OFF_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(4);
endpackage

// File: rtl/stat_sync.sv
module stat_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/stat_flags.sv
module stat_flags #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] ie_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, flag_d;

  // sticky while enabled; dropping the enable is the only clear
  always_comb flag_d = (flag_q | sync_i) & ie_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/stat_cfg_regs.sv
module stat_cfg_regs #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_we_i,
  input  logic         ctrl_we_i,
  input  logic [W-1:0] ie_wr_i,
  input  logic         chen_wr_i,
  input  logic         gie_wr_i,
  output logic [W-1:0] ie_o,
  output logic         chen_o,
  output logic         gie_o,
  output logic         flush_o
);
  logic [W-1:0] ie_q, ie_d;
  logic         chen_q, chen_d;
  logic         gie_q, gie_d;
  logic         flush_q, flush_d;
  logic         cmd_en, ctrl_en;

  // clock enables
  assign cmd_en  = cmd_we_i;
  assign ctrl_en = ctrl_we_i;

  always_comb begin
    ie_d    = ie_wr_i;
    chen_d  = chen_wr_i;
    gie_d   = gie_wr_i;
    flush_d = cmd_en & chen_q & ~chen_wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      chen_q <= 1'b0;
    end else if (cmd_en) begin
      ie_q   <= ie_d;
      chen_q <= chen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gie_q <= 1'b0;
    else if (ctrl_en) gie_q <= gie_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= flush_d;
  end

  assign ie_o    = ie_q;
  assign chen_o  = chen_q;
  assign gie_o   = gie_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/stat_irq_regs.sv
module stat_irq_regs
  import stat_irq_pkg::*;
#(
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_STAT_W = STAT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_ADDR_W-1:0] reg_addr,
  input  logic                reg_we,
  input  logic [P_DATA_W-1:0] reg_wdata,
  output logic [P_DATA_W-1:0] reg_rdata,
  input  logic [P_STAT_W-1:0] stat_i,
  output logic                irq_o,
  output logic                chan_en_o,
  output logic                chan_flush_o
);
  localparam int unsigned IE_POS = P_DATA_W - P_STAT_W;

  logic [1:0]          rst_sync_q;
  logic                rst_n_int;
  logic [P_STAT_W-1:0] stat_sync_w;
  logic [P_STAT_W-1:0] ie_w;
  logic [P_STAT_W-1:0] flag_w;
  logic                chen_w, gie_w, flush_w;
  logic                cmd_we, ctrl_we;
  logic                unused_wbits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign cmd_we  = reg_we && (reg_addr == P_ADDR_W'(OFF_CMD));
  assign ctrl_we = reg_we && (reg_addr == P_ADDR_W'(OFF_CTRL));

  assign unused_wbits = ^{reg_wdata[CHEN_BIT-1:0], reg_wdata[P_DATA_W-1:GIE_BIT+1]};

  stat_sync #(.W(P_STAT_W), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (stat_i),
    .q_o   (stat_sync_w)
  );

  stat_cfg_regs #(.W(P_STAT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_we_i  (cmd_we),
    .ctrl_we_i (ctrl_we),
    .ie_wr_i   (reg_wdata[P_DATA_W-1:IE_POS]),
    .chen_wr_i (reg_wdata[CHEN_BIT]),
    .gie_wr_i  (reg_wdata[GIE_BIT]),
    .ie_o      (ie_w),
    .chen_o    (chen_w),
    .gie_o     (gie_w),
    .flush_o   (flush_w)
  );

  stat_flags #(.W(P_STAT_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .sync_i (stat_sync_w),
    .ie_i   (ie_w),
    .flag_o (flag_w)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      P_ADDR_W'(OFF_CMD): begin
        reg_rdata[P_DATA_W-1:IE_POS] = ie_w;
        reg_rdata[CHEN_BIT]          = chen_w;
      end
      P_ADDR_W'(OFF_STAT): begin
        reg_rdata[P_DATA_W-1:IE_POS] = flag_w;
        reg_rdata[P_STAT_W-1:0]      = stat_sync_w;
      end
      P_ADDR_W'(OFF_CTRL): reg_rdata[GIE_BIT] = gie_w;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o        = gie_w & (|flag_w);
  assign chan_en_o    = chen_w;
  assign chan_flush_o = flush_w;
endmodule

// File: rtl/stat_irq_regs_chk.sv
module stat_irq_regs_chk #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_rdata,
  input logic          irq_o,
  input logic          chan_en_o,
  input logic          chan_flush_o,
  input logic [SW-1:0] ie,
  input logic [SW-1:0] flags,
  input logic          gie
);
  // R9: pulse lasts a single cycle
  p_flush_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_flush_o |=> !chan_flush_o);

  // R9: pulse only where the channel enable just fell
  p_flush_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_flush_o |-> (!chan_en_o && $past(chan_en_o)));

  // R6: interrupt needs the global gate and a flag
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie && (flags != '0)));

  // R5: no flag survives a cycle with its enable low
  p_flag_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(ie)) == '0);

  // R10: a status-offset write leaves the command state alone
  p_stat_write_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == AW'(3)) |=> ($stable(ie) && $stable(chan_en_o) && $stable(gie)));

  // R2: reserved command bits read 0
  always_comb begin
    if (rst_n && reg_addr == AW'(0))
      p_cmd_rsvd_zero_r2: assert (reg_rdata[2:0] == 3'b000);
  end
endmodule

bind stat_irq_regs stat_irq_regs_chk #(.AW(P_ADDR_W), .DW(P_DATA_W), .SW(P_STAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_int),
  .reg_addr     (reg_addr),
  .reg_we       (reg_we),
  .reg_rdata    (reg_rdata),
  .irq_o        (irq_o),
  .chan_en_o    (chan_en_o),
  .chan_flush_o (chan_flush_o),
  .ie           (ie_w),
  .flags        (flag_w),
  .gie          (gie_w)
);

// File: tb/tb_stat_irq_regs.sv
`timescale 1ns/1ps
module tb_stat_irq_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] stat_i = '0;
  logic       irq_o, chan_en_o, chan_flush_o;

  int applied = 0;
  int misses  = 0;
  bit done    = 0;

  // kind: 0 readback, 1 irq, 2 chan_en, 3 flush
  int         q_kind[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  stat_irq_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_i(stat_i),
    .irq_o(irq_o), .chan_en_o(chan_en_o), .chan_flush_o(chan_flush_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(tag);
  endtask

  task automatic expect_pin(input int k, input logic e, input string tag);
    q_kind.push_back(k); q_exp.push_back({7'd0, e}); q_tag.push_back(tag);
  endtask

  task automatic settle();
    @(negedge clk); #0.5;
  endtask

  // monitor: compares queued items on the falling edge
  always @(negedge clk) begin
    while (q_kind.size() > 0) begin
      int         k;
      logic [7:0] e, got;
      string      t;
      k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      case (k)
        0:       got = reg_rdata;
        1:       got = {7'd0, irq_o};
        2:       got = {7'd0, chan_en_o};
        default: got = {7'd0, chan_flush_o};
      endcase
      applied++;
      if (got !== e) begin
        misses++;
        $display("FAIL %s: got %02h expected %02h", t, got, e);
      end
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    expect_rd(3'd0, 8'h00, "R1 cmd"); settle(); #1;
    expect_rd(3'd3, 8'h00, "R1 status"); settle(); #1;
    expect_rd(3'd4, 8'h00, "R1 ctrl");
    expect_pin(1, 1'b0, "R1 irq"); expect_pin(2, 1'b0, "R1 chan_en");
    expect_pin(3, 1'b0, "R1 flush"); settle();

    // R2 / R8 command write with reserved bits set
    tick(); wr(3'd0, 8'hFF);
    expect_rd(3'd0, 8'hF8, "R2 cmd readback"); expect_pin(2, 1'b1, "R8 chan_en");
    expect_pin(3, 1'b0, "R9 no pulse on rise"); settle();
    tick(); wr(3'd4, 8'hFF);
    expect_rd(3'd4, 8'h10, "R7 ctrl readback"); settle();

    // R3 / R4 / R6 status path latency
    tick(); stat_i = 4'b0101;
    tick(); expect_rd(3'd3, 8'h00, "R3 one edge early"); settle();
    tick(); expect_rd(3'd3, 8'h05, "R3 synced"); expect_pin(1, 1'b0, "R4 flag not yet"); settle();
    tick(); expect_rd(3'd3, 8'h55, "R4 flags set"); expect_pin(1, 1'b1, "R6 irq up"); settle();

    // R4 sticky
    tick(); stat_i = 4'b0000;
    repeat (3) tick();
    expect_rd(3'd3, 8'h50, "R4 sticky"); settle();

    // R6 / R7 global gate
    tick(); wr(3'd4, 8'h00);
    expect_pin(1, 1'b0, "R6 gated off"); expect_rd(3'd0, 8'hF8, "R7 cmd kept"); settle(); #1;
    expect_rd(3'd3, 8'h50, "R7 flags kept"); settle();
    tick(); wr(3'd4, 8'h10);
    expect_pin(1, 1'b1, "R6 gated on"); settle();

    // R5 clear by enable
    tick(); wr(3'd0, 8'hE8);
    expect_rd(3'd3, 8'h50, "R5 clear not yet"); settle();
    tick(); expect_rd(3'd3, 8'h40, "R5 flag0 cleared"); expect_pin(1, 1'b1, "R6 flag2 holds irq"); settle();
    tick(); wr(3'd0, 8'h08);
    tick(); expect_rd(3'd3, 8'h00, "R5 all cleared"); expect_pin(1, 1'b0, "R6 irq down"); settle();

    // R4 no flag without enable; R5 re-arm
    tick(); stat_i = 4'b0010;
    repeat (3) tick();
    expect_rd(3'd3, 8'h02, "R4 disabled no flag"); settle();
    tick(); wr(3'd0, 8'h28);
    tick(); expect_rd(3'd3, 8'h22, "R4 flag1 set"); settle();
    tick(); wr(3'd0, 8'h08);
    tick(); expect_rd(3'd3, 8'h02, "R5 flag1 cleared"); settle();
    tick(); wr(3'd0, 8'h28);
    tick(); expect_rd(3'd3, 8'h22, "R5 rearmed"); settle();

    // R10 inert writes and unmapped reads
    tick(); wr(3'd3, 8'h00);
    expect_rd(3'd3, 8'h22, "R10 status write"); settle();
    tick(); wr(3'd7, 8'hFF);
    expect_rd(3'd0, 8'h28, "R10 cmd after unmapped write"); settle(); #1;
    expect_rd(3'd4, 8'h10, "R10 ctrl after unmapped write"); settle(); #1;
    expect_rd(3'd7, 8'h00, "R10 unmapped read"); settle();

    // R9 flush pulse
    tick(); wr(3'd0, 8'h20);
    expect_pin(3, 1'b1, "R9 pulse on fall"); expect_pin(2, 1'b0, "R8 chan_en low"); settle();
    tick(); expect_pin(3, 1'b0, "R9 pulse ends"); expect_rd(3'd3, 8'h22, "R9 flags untouched"); settle();
    tick(); wr(3'd0, 8'h00);
    expect_pin(3, 1'b0, "R9 no pulse 0 to 0"); settle();
    tick(); wr(3'd0, 8'h08);
    expect_pin(3, 1'b0, "R9 no pulse 0 to 1"); expect_pin(2, 1'b1, "R8 chan_en high"); settle();

    tick(); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end
endmodule